// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block holds three state bits for each of a set of external interrupt lines: pending (the interrupt is waiting to be taken), active (its handler is running) and enabled. It is placed between the raw interrupt wires and the priority logic of a processor. It needs no per-line setting for trigger type. A line that pulses and a line that is held high are both handled by one rule. A rising edge arms pending at any time, including while the handler runs. The line level is sampled again when the handler returns, so a source that is still asserting is not lost.

Lines enter through a two-stage synchronizer, and edges are found on the synchronized value. The processor side gives a strobe with an ID when it enters a handler (acknowledge) and another strobe when it leaves one (return). Software writes go through a single write port. A select code picks the action and a data word carries a bit mask, or an ID for the software trigger. Enable and pending are kept apart: a disabled line can still become pending or remain pending. Choosing the winner among pending lines is left to the logic outside this block.

Top module: `irq_state_tracker`

## Requirements
- R1: While a line is synchronized high and its interrupt is not active, its pending bit is set. A line change driven before clock edge k shows on pending_o after edge k+2.
- R2: An acknowledge with ID i sets active bit i and clears pending bit i on the same edge, unless a new rising edge arrives on that edge.
- R3: A rising edge on the synchronized line while the interrupt is active sets pending again, and active stays set.
- R4: A return with ID i clears active bit i. If line i is still high at that edge, pending bit i is set. If the line is low and no other source sets it, pending stays clear.
- R5: Select code 0 sets enable bits and code 1 clears them, acting on 1-bits of wr_data only. Enable never changes pending or active, and no other write or event changes enable.
- R6: Select code 2 sets the pending bits marked by 1-bits of wr_data. Select code 4 sets the single pending bit whose ID is in the low ID_W bits of wr_data.
- R7: Select code 3 clears the pending bits marked by 1-bits of wr_data. Bits written as zero keep their state.
- R8: When a line is high and not active on the same edge as a clear-pending write to its bit, the line wins and pending stays set.
- R9: After a synchronous active-low reset, pending_o, active_o and enable_o are all zero.
- R10: Select codes 5, 6 and 7, and writes with wr_valid low, change no state. A software-trigger ID of NUM_IRQ or above is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_IRQ | Asynchronous interrupt lines, active high |
| ack_valid | input | 1 | Handler-entry strobe |
| ack_id | input | ID_W | ID of the interrupt being entered |
| ret_valid | input | 1 | Handler-exit strobe |
| ret_id | input | ID_W | ID of the interrupt being exited |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write action: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 software trigger |
| wr_data | input | NUM_IRQ | Bit mask, or ID in the low ID_W bits for the software trigger |
| pending_o | output | NUM_IRQ | Pending state per line |
| active_o | output | NUM_IRQ | Active state per line |
| enable_o | output | NUM_IRQ | Enable state per line |

## Verification
Properties are checked on every cycle: an acknowledge leads to active, a return clears active, a high line at return re-arms pending, a high inactive line latches pending, a clear-pending write with the line low empties the bit, and enable holds still unless an enable write targets it. The bench scenarios cover the behaviour over longer spans. These include the exact synchronizer latency, a pulse during an active handler being serviced again, the difference between a return with the line high and with it low, and mixed bit patterns on the set and clear writes. They also cover the ignored select codes and a clear losing to a held line. All of these are swept across every line of an eight-line configuration.

// File: rtl/irq_trk_pkg.sv
// Package: shared write-select encoding for the interrupt state tracker.
// Assumes a 3-bit select field; codes above SEL_SW_TRIG are reserved and inert.
package irq_trk_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SET_EN   = 3'd0,
        SEL_CLR_EN   = 3'd1,
        SEL_SET_PEND = 3'd2,
        SEL_CLR_PEND = 3'd3,
        SEL_SW_TRIG  = 3'd4
    } wr_sel_e;

endpackage

// File: rtl/irq_sync_edge.sv
// Module: two-flop synchronizer plus rising-edge detector for a vector of lines.
// Assumes lines are asynchronous; a pulse must stay high for at least one clock
// period to be seen. lvl_o is the synchronized level, rise_o is high for one
// cycle after each low-to-high change of lvl_o.
module irq_sync_edge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // Two synchronizing stages and a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= lines_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Level and rising edge taken from the synchronized stage.
    always_comb begin
        lvl_o  = sync_q;
        rise_o = sync_q & ~prev_q;
    end

endmodule

// File: rtl/irq_wr_decode.sv
// Module: turns one register write into per-line set/clear masks.
// Assumes at most one write per cycle; only one mask kind can be non-zero.
// The software trigger is folded into the set-pending mask; IDs >= NUM_IRQ are dropped.
module irq_wr_decode
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               wr_valid_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [NUM_IRQ-1:0] wr_data_i,
    output logic [NUM_IRQ-1:0] set_en_o,
    output logic [NUM_IRQ-1:0] clr_en_o,
    output logic [NUM_IRQ-1:0] set_pend_o,
    output logic [NUM_IRQ-1:0] clr_pend_o
);

    localparam int TRIG_W = (ID_W < NUM_IRQ) ? ID_W : NUM_IRQ;

    logic [NUM_IRQ-1:0] trig_onehot;
    logic [ID_W-1:0]    trig_id;

    // Extract the trigger ID from the low data bits.
    always_comb begin
        trig_id = '0;
        trig_id[TRIG_W-1:0] = wr_data_i[TRIG_W-1:0];
    end

    // One-hot expansion of the trigger ID, one comparator per line.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_trig
        assign trig_onehot[g] = (trig_id == ID_W'(g));
    end

    // Select decode: route the data word to the chosen mask.
    always_comb begin
        set_en_o   = '0;
        clr_en_o   = '0;
        set_pend_o = '0;
        clr_pend_o = '0;
        if (wr_valid_i) begin
            unique case (wr_sel_i)
                SEL_SET_EN:   set_en_o   = wr_data_i;
                SEL_CLR_EN:   clr_en_o   = wr_data_i;
                SEL_SET_PEND: set_pend_o = wr_data_i;
                SEL_CLR_PEND: clr_pend_o = wr_data_i;
                SEL_SW_TRIG:  set_pend_o = trig_onehot;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_line_cell.sv
// Module: pending/active/enable state for one interrupt line.
// Assumes lvl_i/rise_i are already synchronized. Priority of pending updates,
// lowest first: clear write, set write, acknowledge, hardware/return re-arm.
module irq_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic rise_i,
    input  logic ack_hit_i,
    input  logic ret_hit_i,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic set_pend_i,
    input  logic clr_pend_i,
    output logic pending_o,
    output logic active_o,
    output logic enable_o
);

    logic pending_q, active_q, enable_q;
    logic pending_d, active_d, enable_d;
    logic hw_arm;

    // Hardware arming: held level when idle, any new edge, or level seen at return.
    always_comb begin
        hw_arm = (lvl_i & ~active_q & ~ack_hit_i) | rise_i | (ret_hit_i & lvl_i);
    end

    // Next-state for pending, active and enable.
    always_comb begin
        pending_d = pending_q;
        if (clr_pend_i) pending_d = 1'b0;
        if (set_pend_i) pending_d = 1'b1;
        if (ack_hit_i)  pending_d = 1'b0;
        if (hw_arm)     pending_d = 1'b1;

        active_d = active_q;
        if (ret_hit_i) active_d = 1'b0;
        if (ack_hit_i) active_d = 1'b1;

        enable_d = enable_q;
        if (set_en_i) enable_d = 1'b1;
        if (clr_en_i) enable_d = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            active_q  <= 1'b0;
            enable_q  <= 1'b0;
        end else begin
            pending_q <= pending_d;
            active_q  <= active_d;
            enable_q  <= enable_d;
        end
    end

    assign pending_o = pending_q;
    assign active_o  = active_q;
    assign enable_o  = enable_q;

    assert_level_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i && !active_q && !ack_hit_i) |=> pending_q);

    assert_ack_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit_i |=> active_q);

    assert_edge_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && active_q) |=> pending_q);

    assert_ret_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit_i && !ack_hit_i) |=> !active_q);

    assert_ret_resample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit_i && lvl_i) |=> pending_q);

    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(enable_q));

    assert_clear_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend_i && !lvl_i && !set_pend_i) |=> !pending_q);

    assert_line_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend_i && lvl_i && !active_q && !ack_hit_i) |=> pending_q);

endmodule

// File: rtl/irq_state_tracker.sv
// Module: top of the interrupt pending/active tracker.
// Assumes one write, at most one acknowledge and at most one return per cycle.
// Lines are synchronized internally; all state updates on the rising clock edge.
module irq_state_tracker
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               ack_valid,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               ret_valid,
    input  logic [ID_W-1:0]    ret_id,
    input  logic               wr_valid,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [NUM_IRQ-1:0] wr_data,
    output logic [NUM_IRQ-1:0] pending_o,
    output logic [NUM_IRQ-1:0] active_o,
    output logic [NUM_IRQ-1:0] enable_o
);

    logic [NUM_IRQ-1:0] lvl, rise;
    logic [NUM_IRQ-1:0] set_en, clr_en, set_pend, clr_pend;
    logic [NUM_IRQ-1:0] ack_hit, ret_hit;

    // Line synchronization and edge detection.
    irq_sync_edge #(.WIDTH(NUM_IRQ)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines),
        .lvl_o   (lvl),
        .rise_o  (rise)
    );

    // Register write decode into per-line masks.
    irq_wr_decode #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) dec_i (
        .wr_valid_i (wr_valid),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .set_en_o   (set_en),
        .clr_en_o   (clr_en),
        .set_pend_o (set_pend),
        .clr_pend_o (clr_pend)
    );

    // Per-line ID match and state cell.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign ack_hit[g] = ack_valid && (ack_id == ID_W'(g));
        assign ret_hit[g] = ret_valid && (ret_id == ID_W'(g));

        irq_line_cell cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (lvl[g]),
            .rise_i     (rise[g]),
            .ack_hit_i  (ack_hit[g]),
            .ret_hit_i  (ret_hit[g]),
            .set_en_i   (set_en[g]),
            .clr_en_i   (clr_en[g]),
            .set_pend_i (set_pend[g]),
            .clr_pend_i (clr_pend[g]),
            .pending_o  (pending_o[g]),
            .active_o   (active_o[g]),
            .enable_o   (enable_o[g])
        );
    end

    assert_one_mask_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|set_en, |clr_en, |set_pend, |clr_pend}));

    assert_reserved_sel_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel > SEL_W'(SEL_SW_TRIG)) |-> (set_en == '0 && clr_en == '0 && set_pend == '0 && clr_pend == '0));

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

endmodule

// File: tb/irq_state_tracker_tb_top.sv
module irq_state_tracker_tb_top;

    localparam int N    = 8;
    localparam int ID_W = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   irq_lines;
    logic           ack_valid, ret_valid, wr_valid;
    logic [ID_W-1:0] ack_id, ret_id;
    logic [2:0]     wr_sel;
    logic [N-1:0]   wr_data;
    logic [N-1:0]   pending_o, active_o, enable_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_state_tracker #(.NUM_IRQ(N), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .ret_valid(ret_valid), .ret_id(ret_id),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .pending_o(pending_o), .active_o(active_o), .enable_o(enable_o)
    );

    task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [N-1:0] data);
        wr_valid = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_valid = 1'b0; wr_data = '0;
    endtask

    task automatic ack(input int id);
        ack_valid = 1'b1; ack_id = ID_W'(id);
        tick();
        ack_valid = 1'b0;
    endtask

    task automatic ret(input int id);
        ret_valid = 1'b1; ret_id = ID_W'(id);
        tick();
        ret_valid = 1'b0;
    endtask

    initial begin
        irq_lines = '0; ack_valid = 0; ret_valid = 0; wr_valid = 0;
        ack_id = '0; ret_id = '0; wr_sel = '0; wr_data = '0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R9 reset state
        chk("R9", "pending", pending_o, '0);
        chk("R9", "active", active_o, '0);
        chk("R9", "enable", enable_o, '0);

        // R5 enable set/clear, write-one, independent of pending
        for (int i = 0; i < N; i++) begin
            wr(3'd0, N'(1) << i);
            chk("R5", "set one enable", enable_o, N'((1 << (i + 1)) - 1));
        end
        wr(3'd1, 8'h55);
        chk("R5", "clear pattern", enable_o, 8'hAA);
        wr(3'd1, 8'h00);
        chk("R5", "zero clear inert", enable_o, 8'hAA);
        wr(3'd0, 8'h00);
        chk("R5", "zero set inert", enable_o, 8'hAA);
        chk("R5", "pending untouched", pending_o, '0);
        wr(3'd1, 8'hFF);
        chk("R5", "clear all", enable_o, '0);

        // R6 software trigger per ID, R7 clear it
        for (int i = 0; i < N; i++) begin
            wr(3'd4, N'(i));
            chk("R6", "sw trigger", pending_o, N'(1) << i);
            wr(3'd3, N'(1) << i);
            chk("R7", "clear trigger", pending_o, '0);
        end
        wr(3'd2, 8'hA5);
        chk("R6", "set pattern", pending_o, 8'hA5);
        wr(3'd3, 8'h0F);
        chk("R7", "clear low nibble", pending_o, 8'hA0);
        wr(3'd3, 8'h00);
        chk("R7", "zero clear inert", pending_o, 8'hA0);
        // R10 reserved codes and idle strobes
        for (int s = 5; s < 8; s++) begin
            wr(3'(s), 8'hFF);
            chk("R10", "reserved pending", pending_o, 8'hA0);
            chk("R10", "reserved enable", enable_o, '0);
        end
        wr_sel = 3'd2; wr_data = 8'hFF; tick(); wr_data = '0;
        chk("R10", "wr_valid low", pending_o, 8'hA0);
        wr(3'd3, 8'hFF);
        chk("R7", "clear all", pending_o, '0);

        // Per-line hardware sequences
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            // R1 pulse latched with exact latency
            irq_lines = b; tick(); irq_lines = '0;
            tick();
            chk("R1", "not yet pending", pending_o, '0);
            tick();
            chk("R1", "pulse latched", pending_o, b);
            tick(2);
            // R2 acknowledge
            ack(i);
            chk("R2", "active set", active_o, b);
            chk("R2", "pending cleared", pending_o, '0);
            // R3 new pulse during handler
            irq_lines = b; tick(); irq_lines = '0; tick(4);
            chk("R3", "re-armed", pending_o, b);
            chk("R3", "still active", active_o, b);
            // R4 return, pending kept
            ret(i);
            chk("R4", "active cleared", active_o, '0);
            chk("R4", "pending kept", pending_o, b);
            // R4 return with line low
            ack(i);
            ret(i);
            chk("R4", "low line no rearm", pending_o, '0);
            chk("R4", "low line inactive", active_o, '0);
            // R4 level still high at return
            irq_lines = b; tick(4);
            chk("R1", "level latched", pending_o, b);
            ack(i);
            chk("R2", "level ack clears", pending_o, '0);
            tick(2);
            chk("R3", "held level no rearm", pending_o, '0);
            ret(i);
            chk("R4", "level resampled", pending_o, b);
            // R8 line beats clear while held
            wr(3'd3, b);
            chk("R8", "line wins clear", pending_o, b);
            irq_lines = '0; tick(3);
            wr(3'd3, b);
            chk("R7", "clear after release", pending_o, '0);
            chk("R5", "enable unaffected", enable_o, '0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule